// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called A and B, in both directions. Each direction has its own capture register and its own source select. With the select low, the opposite port carries the live value of the source bus. With it high, the opposite port carries the captured word. A separate enable per direction decides whether the block drives the opposite port at all. A-to-B uses an active-high enable, and B-to-A uses an active-low one.

Bus pins are split into an input value, an external-driver-present flag, an output value and a per-bit output-enable vector, so no tri-state nets are needed. Inside the block, each bus resolves to one value. An external driver wins. Otherwise the block's own drive is used. Otherwise a held copy of the last driven value is used. This is what lets a loop with both directions live and enabled keep its state after the outside world lets go.

Capture strobes are edge-detected in the system clock domain. Both output paths are registered, so a select change moves an output in one step from the old source to the new one, with no mixed value in between. This block has no data stream, so every pin is a plain control or data pin with no handshake.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `a_out`, `b_out`, `a_oe` and `b_oe` are all zero, and both capture registers hold zero.
- R2: With `sel_ab` low, the clock edge that samples a given A bus value puts that value on `b_out`, regardless of `en_ab`.
- R3: With `sel_ba` low, the clock edge that samples a given B bus value puts that value on `a_out`, regardless of `en_ba_n`.
- R4: The A register loads the resolved A bus at the first clock where `cap_ab` is seen high after being low, and the B register does the same with `cap_ba` and the B bus. Keeping a strobe high does not load the register again.
- R5: A capture happens whatever the values of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n` are.
- R6: With `sel_ab` high, the next edge puts the A register on `b_out`. With `sel_ba` high, the next edge puts the B register on `a_out`.
- R7: One edge after `en_ab` is high, `b_oe` is all ones, and one edge after it is low, `b_oe` is all zeros. `en_ba_n` drives `a_oe` in the same way, with inverted polarity.
- R8: After a select change, the output keeps its old source until the next clock edge and then shows the new source.
- R9: Each bus resolves in this order: the external value when its flag is high, else the block's own output when its `_oe` is set, else the last resolved value. An undriven bus therefore keeps its value.
- R10: With both selects low and both directions enabled, after one bus has been driven externally and then released, both ports keep carrying that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | Value driven onto the A bus from outside |
| a_ext | input | 1 | High while an outside driver is active on the A bus |
| a_out | output | W | Value the block drives onto the A bus |
| a_oe | output | W | Per-bit drive enable for the A bus |
| b_in | input | W | Value driven onto the B bus from outside |
| b_ext | input | 1 | High while an outside driver is active on the B bus |
| b_out | output | W | Value the block drives onto the B bus |
| b_oe | output | W | Per-bit drive enable for the B bus |
| cap_ab | input | 1 | A-side capture strobe, acts on its rising edge |
| cap_ba | input | 1 | B-side capture strobe, acts on its rising edge |
| sel_ab | input | 1 | B port source: 0 live A bus, 1 A register |
| sel_ba | input | 1 | A port source: 0 live B bus, 1 B register |
| en_ab | input | 1 | Drive enable for the B port, active high |
| en_ba_n | input | 1 | Drive enable for the A port, active low |

## Verification
The hardest state to reach is the closed loop with nobody driving. The stimulus enables both directions in live mode, drives only the A bus from outside for a few cycles until the value has gone through B and back, and then drops the external flag. It then checks over several cycles that both ports keep the value, and captures the undriven bus to show that the held value is what the block resolves internally. A second sequence reaches the undriven-and-disabled case: it drives A once, releases it with the enables off, and reads the held word back through a capture and stored-mode transfer.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_bus.sv
module xcvr_bus #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_en,
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] own_oe,
  input  logic [W-1:0] own_val,
  output logic [W-1:0] bus_val
);
  logic [W-1:0] held_q;
  logic         own_drv;

  assign own_drv = |own_oe;

  // priority: outside driver, then own driver, then held value
  always_comb begin
    if (ext_en)       bus_val = ext_val;
    else if (own_drv) bus_val = own_val;
    else              bus_val = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 held_q <= '0;
    else if (ext_en || own_drv) held_q <= bus_val;
  end
endmodule

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic rise;

  assign rise = strobe && !strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (rise) q <= d;
    end
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         sel,
  input  logic         en,
  output logic [W-1:0] out_val,
  output logic [W-1:0] oe
);
  src_sel_e     src;
  logic [W-1:0] pick;

  assign src  = src_sel_e'(sel);
  assign pick = (src == SRC_STORED) ? stored : live;

  // registered so a select change moves in one step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_val <= '0;
      oe      <= '0;
    end else begin
      out_val <= pick;
      oe      <= {W{en}};
    end
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n
);
  logic [W-1:0] a_bus, b_bus;
  logic [W-1:0] a_store, b_store;
  logic         en_ba;

  assign en_ba = !en_ba_n;

  xcvr_bus #(.W(W)) u_abus (
    .clk(clk), .rst_n(rst_n), .ext_en(a_ext), .ext_val(a_in),
    .own_oe(a_oe), .own_val(a_out), .bus_val(a_bus)
  );
  xcvr_bus #(.W(W)) u_bbus (
    .clk(clk), .rst_n(rst_n), .ext_en(b_ext), .ext_val(b_in),
    .own_oe(b_oe), .own_val(b_out), .bus_val(b_bus)
  );

  xcvr_capture #(.W(W)) u_cap_a (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ab), .d(a_bus), .q(a_store)
  );
  xcvr_capture #(.W(W)) u_cap_b (
    .clk(clk), .rst_n(rst_n), .strobe(cap_ba), .d(b_bus), .q(b_store)
  );

  xcvr_lane #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .live(a_bus), .stored(a_store),
    .sel(sel_ab), .en(en_ab), .out_val(b_out), .oe(b_oe)
  );
  xcvr_lane #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .live(b_bus), .stored(b_store),
    .sel(sel_ba), .en(en_ba), .out_val(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic         a_ext,
  input logic [W-1:0] b_in,
  input logic         b_ext,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] a_store,
  input logic [W-1:0] b_store
);
  assert_live_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ext && !sel_ab) |=> (b_out == $past(a_in)));

  assert_live_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ext && !sel_ba) |=> (a_out == $past(b_in)));

  assert_cap_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_ab) |=> (a_store == $past(a_bus)));

  assert_cap_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_ba) |=> (b_store == $past(b_bus)));

  assert_oe_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_ab |=> (b_oe == {W{1'b1}}));

  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_ba_n |=> (a_oe == '0));

  assert_hold_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !a_ext && (a_oe == '0)) |-> (a_bus == $past(a_bus)));

  assert_hold_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !b_ext && (b_oe == '0)) |-> (b_bus == $past(b_bus)));
endmodule

bind regbus_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext(a_ext), .b_in(b_in),
  .b_ext(b_ext), .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab),
  .en_ba_n(en_ba_n), .cap_ab(cap_ab), .cap_ba(cap_ba), .a_oe(a_oe),
  .b_oe(b_oe), .a_out(a_out), .b_out(b_out), .a_bus(a_bus), .b_bus(b_bus),
  .a_store(a_store), .b_store(b_store)
);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
  logic a_ext, b_ext, cap_ab, cap_ba, sel_ab, sel_ba, en_ab, en_ba_n;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext(a_ext), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n)
  );

  // row: a_in, b_in, {sel_ab,sel_ba,en_ab,en_ba_n}, exp b_out, exp b_oe bit,
  //      exp a_out, exp a_oe bit (both buses driven from outside)
  localparam logic [37:0] VEC [6] = '{
    {8'h3C, 8'hA5, 4'b0010, 8'h3C, 1'b1, 8'hA5, 1'b1},
    {8'hFF, 8'h00, 4'b1010, 8'h00, 1'b1, 8'h00, 1'b1},
    {8'h12, 8'h34, 4'b0101, 8'h12, 1'b0, 8'h00, 1'b0},
    {8'h81, 8'h7E, 4'b0011, 8'h81, 1'b1, 8'h7E, 1'b0},
    {8'h00, 8'hFF, 4'b1100, 8'h00, 1'b0, 8'h00, 1'b1},
    {8'hC3, 8'h5A, 4'b0000, 8'hC3, 1'b0, 8'h5A, 1'b1}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_in = '0; b_in = '0; a_ext = 1'b0; b_ext = 1'b0;
    cap_ab = 1'b0; cap_ba = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    en_ab = 1'b0; en_ba_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 a_out", a_out, 8'h00);
    check("R1 b_out", b_out, 8'h00);
    check("R1 a_oe", a_oe, 8'h00);
    check("R1 b_oe", b_oe, 8'h00);
    rst_n = 1'b1;

    // vector table: live, stored (registers still zero) and enables
    a_ext = 1'b1; b_ext = 1'b1;
    for (int i = 0; i < 6; i++) begin
      a_in = VEC[i][37:30]; b_in = VEC[i][29:22];
      {sel_ab, sel_ba, en_ab, en_ba_n} = VEC[i][21:18];
      tick();
      check("R2/R6 b_out", b_out, VEC[i][17:10]);
      check("R7 b_oe", b_oe, {W{VEC[i][9]}});
      check("R3/R6 a_out", a_out, VEC[i][8:1]);
      check("R7 a_oe", a_oe, {W{VEC[i][0]}});
    end

    // R4 R5: capture while both directions disabled and in live mode
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b0; en_ba_n = 1'b1;
    a_in = 8'h5D; b_in = 8'hE7; cap_ab = 1'b1; cap_ba = 1'b1;
    tick();
    a_in = 8'h11; b_in = 8'h22;   // strobes stay high: no second load
    tick();
    cap_ab = 1'b0; cap_ba = 1'b0;
    tick();
    check("R8 b_out before select edge", b_out, 8'h11);
    sel_ab = 1'b1; en_ab = 1'b1; sel_ba = 1'b1; en_ba_n = 1'b0;
    #1;
    check("R8 b_out held until clock", b_out, 8'h11);
    tick();
    check("R4 R5 R6 b_out stored", b_out, 8'h5D);
    check("R4 R5 R6 a_out stored", a_out, 8'hE7);
    check("R7 b_oe on", b_oe, 8'hFF);

    // R9: drive A once with no enables, release, capture the held value
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b0; en_ba_n = 1'b1;
    b_ext = 1'b0; a_in = 8'h4B;
    repeat (2) tick();
    a_ext = 1'b0; a_in = 8'hFF;
    repeat (3) tick();
    cap_ab = 1'b1;
    tick();
    cap_ab = 1'b0; sel_ab = 1'b1; en_ab = 1'b1;
    tick();
    check("R9 held A bus captured", b_out, 8'h4B);

    // R10: closed live loop, drive A, then release both buses
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1; en_ba_n = 1'b0;
    a_ext = 1'b1; a_in = 8'h96; b_ext = 1'b0;
    repeat (3) tick();
    check("R10 b_out loop driven", b_out, 8'h96);
    check("R10 a_out loop driven", a_out, 8'h96);
    a_ext = 1'b0; a_in = 8'h00;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R10 a_out held", a_out, 8'h96);
      check("R10 b_out held", b_out, 8'h96);
    end
    cap_ab = 1'b1;
    tick();
    cap_ab = 1'b0; sel_ab = 1'b1;
    tick();
    check("R10 R9 A bus held value", b_out, 8'h96);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule